// File: doc/BRIEF.md
# Backplane Error and Timeout Capture Register

This block holds the error status register of a system backplane together with the register that records where a failed access went. When a register-space access times out, the block stores the failing longword address. For a virtual reference it also stores the current access mode. It raises a timeout flag and tracks later errors through a multiple-error bit instead of overwriting the first capture. An error-confirm event sets its own flag, or the multiple-error bit if that flag is already up.

Each error event also produces a request to the processor one cycle later. A read timeout or a confirm requests a machine check. A write timeout raises a memory-error interrupt request instead. After the machine-check sequencer has saved its error frame, it pulses a clear input that wipes the timeout group of bits.

Software writes to the error register mix plain-write, write-one-to-clear and group-clear semantics. A corrected-read-data (CRD) interrupt request is recomputed from the enable and CRD bits on every software write to the error register. A small two-state machine owns the timeout flag and the address capture:
- `TMO_ARMED` means no timeout is held. `TMO_ARMED -> TMO_LATCHED` happens on a timeout event, and that transition stores the address.
- `TMO_LATCHED -> TMO_ARMED` happens when software writes 1 to bit 12, or when the machine-check clear pulse arrives.

Top module: `bus_err_capture`

## Requirements
- R1: After reset the error register reads 0x0000_0000, the timeout-address register reads 0x0000_0000, and `crd_irq`, `mchk_req` and `memerr_req` are all 0.
- R2: A timeout event while bit 12 is clear stores the physical address shifted right by 2 into the timeout-address register and sets bit 12 (0x1000), visible the cycle after the event. For a physical reference, bits 31:29 of the stored word are 0.
- R3: When `tmo_virt` is 1, the stored word additionally has bit 29 set and `tmo_mode` in bits 31:30.
- R4: A timeout event while bit 12 is set leaves the timeout-address register unchanged and sets the multiple-error bit, bit 2.
- R5: An error-confirm event sets bit 8 if bit 8 is clear, and otherwise sets bit 2. In both cases `mchk_req` is 1 for the following cycle.
- R6: A timeout with `tmo_is_rd`=1 makes `mchk_req` 1 for exactly the next cycle. A timeout with `tmo_is_rd`=0 makes `memerr_req` 1 for exactly the next cycle and leaves `mchk_req` 0.
- R7: The error register output shows only the bits in mask 0x0000_FDFE. Of these, only bit 15 (CRD interrupt enable) takes the written data directly. Written ones in any other bit position do not set that bit.
- R8: Writing 1 to any bit in 0x70C0 (bits 14, 13, 12, 7, 6) clears that bit. Writing 1 to bit 8 alone does not clear bit 8.
- R9: Writing 1 to bit 12 also clears bits 11:10, 8 and 2. Writing 1 to bit 6 clears bits 6, 11:10 and 3, and leaves bits 12, 8 and 2 unchanged.
- R10: A CRD event sets bit 14. `crd_irq` is updated only on a software write to the error register, where it becomes bit 15 AND bit 14 of the value after the write. At all other times it holds.
- R11: A `mchk_clr` pulse clears bits 12, 11:10, 8 and 2 and leaves bits 15 and 14 alone. The next timeout after the pulse captures a new address.
- R12: When an event and a software write or `mchk_clr` occur in the same cycle, the event's set action wins over the clear.
- R13: A write with `reg_sel`=1 targets the read-only timeout-address register. It changes neither register and does not update `crd_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_evt | input | 1 | Register-space access timed out (one-cycle pulse) |
| tmo_is_rd | input | 1 | The timed-out access was a read |
| tmo_paddr | input | PA_W | Physical byte address of the failed access |
| tmo_virt | input | 1 | The failed reference was virtual |
| tmo_mode | input | 2 | Current access mode at the time of the failure |
| cnf_evt | input | 1 | Error-confirm event (one-cycle pulse) |
| crd_evt | input | 1 | Corrected-read-data event (one-cycle pulse) |
| mchk_clr | input | 1 | Clear pulse from the machine-check sequencer |
| reg_sel | input | 1 | Write target: 0 error register, 1 timeout-address register |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 32 | Software write data |
| err_reg | output | 32 | Error register value, masked for reading |
| tmo_addr | output | 32 | Timeout-address register value |
| crd_irq | output | 1 | CRD interrupt request |
| mchk_req | output | 1 | Machine-check request pulse |
| memerr_req | output | 1 | Memory-error interrupt request pulse |

## Verification
The assertions check on every cycle the following rules:
- a first timeout raises bit 12;
- a repeated timeout freezes the address and raises bit 2;
- the address never moves without a timeout;
- a confirm always yields bit 8 and a machine-check request;
- every request pulse traces back to the right event class;
- `crd_irq` changes only on error-register writes, and then to the enable AND CRD value;
- the sequencer clear empties the timeout group.

The exact captured address words, the mode packing for virtual references, and the group-clear results of particular write values can only be shown by the bench's scenarios, since they depend on chosen data. The same holds for same-cycle collisions between events and clears, and for the ignored writes to the address register.

// File: rtl/bec_pkg.sv
package bec_pkg;

    localparam int REG_W = 32;

    // Error register bit positions
    localparam int B_CRD_IE  = 15;
    localparam int B_CRD     = 14;
    localparam int B_TMO     = 12;
    localparam int B_CNF     = 8;
    localparam int B_IB_TMO  = 6;
    localparam int B_MULT    = 2;

    // Timeout-address word layout
    localparam int TA_VIRT_B = 29;
    localparam int TA_MODE_L = 30;

    localparam logic [REG_W-1:0] RD_MASK     = 32'h0000_FDFE;
    localparam logic [REG_W-1:0] WR_MASK     = 32'h0000_8000;
    localparam logic [REG_W-1:0] W1C_MASK    = 32'h0000_70C0;
    localparam logic [REG_W-1:0] TMO_GROUP   = 32'h0000_1D04; // 12, 11:10, 8, 2
    localparam logic [REG_W-1:0] IBT_GROUP   = 32'h0000_0C48; // 11:10, 6, 3
    localparam logic [REG_W-1:0] MCHK_GROUP  = 32'h0000_1D04;
    localparam logic [REG_W-1:0] TMO_BITMASK = 32'h0000_1000;

    typedef enum logic [0:0] {
        TMO_ARMED   = 1'b0,
        TMO_LATCHED = 1'b1
    } tmo_state_t;

    function automatic logic [REG_W-1:0] pack_tmo_word(
        input logic [REG_W-1:0] pa,
        input logic             virt,
        input logic [1:0]       mode
    );
        logic [REG_W-1:0] w;
        w = pa >> 2;
        if (virt) begin
            w[TA_VIRT_B]           = 1'b1;
            w[TA_MODE_L+1:TA_MODE_L] = mode;
        end
        return w;
    endfunction

endpackage

// File: rtl/bec_tmo_fsm.sv
module bec_tmo_fsm
    import bec_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_evt,
    input  logic [PA_W-1:0]  tmo_paddr,
    input  logic             tmo_virt,
    input  logic [1:0]       tmo_mode,
    input  logic             clr_req,
    output logic             tmo_flag,
    output logic [REG_W-1:0] tmo_addr
);

    tmo_state_t state_q, state_d;
    logic       capture;
    logic [REG_W-1:0] pa_ext;

    assign pa_ext = REG_W'(tmo_paddr);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMO_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            TMO_ARMED: begin
                if (tmo_evt) begin
                    capture = 1'b1;
                    state_d = TMO_LATCHED;   // set beats a same-cycle clear
                end
            end
            TMO_LATCHED: begin
                if (clr_req) state_d = TMO_ARMED;
            end
            default: state_d = TMO_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       tmo_addr <= '0;
        else if (capture) tmo_addr <= pack_tmo_word(pa_ext, tmo_virt, tmo_mode);
    end

    assign tmo_flag = (state_q == TMO_LATCHED);

endmodule

// File: rtl/bec_status.sv
module bec_status
    import bec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_evt,
    input  logic             tmo_flag,
    input  logic             cnf_evt,
    input  logic             crd_evt,
    input  logic             mchk_clr,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] status,
    output logic             crd_irq
);

    logic [REG_W-1:0] st_q, st_d, clr, set;
    logic             crd_q;

    always_comb begin
        clr = '0;
        set = '0;
        if (wr_en) begin
            clr = wdata & W1C_MASK;
            if (wdata[B_TMO])    clr = clr | TMO_GROUP;
            if (wdata[B_IB_TMO]) clr = clr | IBT_GROUP;
        end
        if (mchk_clr) clr = clr | MCHK_GROUP;

        if (tmo_evt && tmo_flag) set[B_MULT] = 1'b1;
        if (cnf_evt) begin
            if (st_q[B_CNF]) set[B_MULT] = 1'b1;
            else             set[B_CNF]  = 1'b1;
        end
        if (crd_evt) set[B_CRD] = 1'b1;

        st_d = (st_q & ~clr) | set;
        if (wr_en) st_d = (st_d & ~WR_MASK) | (wdata & WR_MASK);
        st_d = st_d & ~TMO_BITMASK;          // bit 12 lives in the FSM
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            crd_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (wr_en) crd_q <= st_d[B_CRD_IE] & st_d[B_CRD];
        end
    end

    assign status  = (st_q & ~TMO_BITMASK) | (tmo_flag ? TMO_BITMASK : '0);
    assign crd_irq = crd_q;

endmodule

// File: rtl/bec_req.sv
module bec_req (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo_evt,
    input  logic tmo_is_rd,
    input  logic cnf_evt,
    output logic mchk_req,
    output logic memerr_req
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mchk_req   <= 1'b0;
            memerr_req <= 1'b0;
        end else begin
            mchk_req   <= cnf_evt | (tmo_evt & tmo_is_rd);
            memerr_req <= tmo_evt & ~tmo_is_rd;
        end
    end

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
    import bec_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tmo_evt,
    input  logic            tmo_is_rd,
    input  logic [PA_W-1:0] tmo_paddr,
    input  logic            tmo_virt,
    input  logic [1:0]      tmo_mode,
    input  logic            cnf_evt,
    input  logic            crd_evt,
    input  logic            mchk_clr,
    input  logic            reg_sel,
    input  logic            reg_wr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     err_reg,
    output logic [31:0]     tmo_addr,
    output logic            crd_irq,
    output logic            mchk_req,
    output logic            memerr_req
);

    localparam logic SEL_ERR = 1'b0;

    logic             err_wr;
    logic             tmo_clr;
    logic             tmo_flag;
    logic [REG_W-1:0] status;

    assign err_wr  = reg_wr && (reg_sel == SEL_ERR);
    assign tmo_clr = (err_wr && reg_wdata[B_TMO]) || mchk_clr;

    bec_tmo_fsm #(.PA_W(PA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmo_evt   (tmo_evt),
        .tmo_paddr (tmo_paddr),
        .tmo_virt  (tmo_virt),
        .tmo_mode  (tmo_mode),
        .clr_req   (tmo_clr),
        .tmo_flag  (tmo_flag),
        .tmo_addr  (tmo_addr)
    );

    bec_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmo_evt  (tmo_evt),
        .tmo_flag (tmo_flag),
        .cnf_evt  (cnf_evt),
        .crd_evt  (crd_evt),
        .mchk_clr (mchk_clr),
        .wr_en    (err_wr),
        .wdata    (reg_wdata),
        .status   (status),
        .crd_irq  (crd_irq)
    );

    bec_req u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmo_evt    (tmo_evt),
        .tmo_is_rd  (tmo_is_rd),
        .cnf_evt    (cnf_evt),
        .mchk_req   (mchk_req),
        .memerr_req (memerr_req)
    );

    assign err_reg = status & RD_MASK;

endmodule

// File: rtl/bus_err_capture_chk.sv
module bus_err_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tmo_evt,
    input logic        tmo_is_rd,
    input logic        cnf_evt,
    input logic        mchk_clr,
    input logic        reg_sel,
    input logic        reg_wr,
    input logic [31:0] err_reg,
    input logic [31:0] tmo_addr,
    input logic        crd_irq,
    input logic        mchk_req,
    input logic        memerr_req
);

    assert_first_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_evt && !err_reg[12]) |=> err_reg[12]);

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_evt && err_reg[12]) |=> ($stable(tmo_addr) && err_reg[2]));

    assert_addr_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_evt |=> $stable(tmo_addr));

    assert_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnf_evt |=> (err_reg[8] && mchk_req));

    assert_mchk_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_req |-> $past(cnf_evt || (tmo_evt && tmo_is_rd)));

    assert_memerr_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        memerr_req |-> $past(tmo_evt && !tmo_is_rd));

    assert_crd_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel) |=> (crd_irq == (err_reg[15] && err_reg[14])));

    assert_crd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !reg_sel) |=> $stable(crd_irq));

    assert_mchk_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mchk_clr && !tmo_evt && !cnf_evt) |=> ((err_reg & 32'h0000_1D04) == 32'h0));

endmodule

bind bus_err_capture bus_err_capture_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmo_evt    (tmo_evt),
    .tmo_is_rd  (tmo_is_rd),
    .cnf_evt    (cnf_evt),
    .mchk_clr   (mchk_clr),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .err_reg    (err_reg),
    .tmo_addr   (tmo_addr),
    .crd_irq    (crd_irq),
    .mchk_req   (mchk_req),
    .memerr_req (memerr_req)
);

// File: tb/bus_err_capture_tb.sv
module bus_err_capture_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmo_evt = 1'b0, tmo_is_rd = 1'b0, tmo_virt = 1'b0;
    logic [31:0] tmo_paddr = '0;
    logic [1:0]  tmo_mode = '0;
    logic        cnf_evt = 1'b0, crd_evt = 1'b0, mchk_clr = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] err_reg, tmo_addr;
    logic        crd_irq, mchk_req, memerr_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_err_capture u_dut (
        .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .tmo_is_rd(tmo_is_rd),
        .tmo_paddr(tmo_paddr), .tmo_virt(tmo_virt), .tmo_mode(tmo_mode),
        .cnf_evt(cnf_evt), .crd_evt(crd_evt), .mchk_clr(mchk_clr),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .err_reg(err_reg), .tmo_addr(tmo_addr), .crd_irq(crd_irq),
        .mchk_req(mchk_req), .memerr_req(memerr_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // advance one edge, then settle away from it
    task automatic step();
        @(posedge clk);
        #1;
        tmo_evt = 0; cnf_evt = 0; crd_evt = 0; mchk_clr = 0; reg_wr = 0; reg_sel = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
    endtask

    task automatic timeout(input logic [31:0] pa, input logic rd,
                           input logic virt, input logic [1:0] mode);
        tmo_evt = 1; tmo_paddr = pa; tmo_is_rd = rd; tmo_virt = virt; tmo_mode = mode;
    endtask

    task automatic wr_err(input logic [31:0] d);
        reg_wr = 1; reg_sel = 0; reg_wdata = d;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 err_reg", err_reg, 32'h0);
        chk("R1 tmo_addr", tmo_addr, 32'h0);
        chk("R1 crd_irq", {31'b0, crd_irq}, 32'h0);
        chk("R1 mchk_req", {31'b0, mchk_req}, 32'h0);
        chk("R1 memerr_req", {31'b0, memerr_req}, 32'h0);
    endtask

    task automatic t_phys_capture();
        do_reset();
        timeout(32'h2000_1234, 1, 0, 2'b00); step();
        chk("R2 addr", tmo_addr, 32'h0800_048D);
        chk("R2 err_reg", err_reg, 32'h0000_1000);
    endtask

    task automatic t_virt_capture();
        do_reset();
        timeout(32'h0000_0100, 1, 1, 2'b11); step();
        chk("R3 addr mode3", tmo_addr, 32'hE000_0040);
        do_reset();
        timeout(32'h0000_0ABC, 1, 1, 2'b01); step();
        chk("R3 addr mode1", tmo_addr, 32'h6000_02AF);
    endtask

    task automatic t_multi();
        do_reset();
        timeout(32'h0000_0100, 1, 0, 2'b00); step();
        timeout(32'h0000_0200, 1, 1, 2'b10); step();
        chk("R4 addr kept", tmo_addr, 32'h0000_0040);
        chk("R4 mult", err_reg, 32'h0000_1004);
    endtask

    task automatic t_confirm();
        do_reset();
        cnf_evt = 1; step();
        chk("R5 first cnf", err_reg, 32'h0000_0100);
        chk("R5 mchk", {31'b0, mchk_req}, 32'h1);
        step();
        chk("R5 mchk drop", {31'b0, mchk_req}, 32'h0);
        cnf_evt = 1; step();
        chk("R5 second cnf", err_reg, 32'h0000_0104);
        chk("R5 mchk again", {31'b0, mchk_req}, 32'h1);
    endtask

    task automatic t_requests();
        do_reset();
        timeout(32'h0000_0040, 0, 0, 2'b00); step();
        chk("R6 write tmo memerr", {31'b0, memerr_req}, 32'h1);
        chk("R6 write tmo no mchk", {31'b0, mchk_req}, 32'h0);
        step();
        chk("R6 memerr pulse", {31'b0, memerr_req}, 32'h0);
        timeout(32'h0000_0040, 1, 0, 2'b00); step();
        chk("R6 read tmo mchk", {31'b0, mchk_req}, 32'h1);
        chk("R6 read tmo no memerr", {31'b0, memerr_req}, 32'h0);
        step();
        chk("R6 mchk pulse", {31'b0, mchk_req}, 32'h0);
    endtask

    task automatic t_mask_write();
        do_reset();
        wr_err(32'hFFFF_7FFF); step();
        chk("R7 no plain set", err_reg, 32'h0);
        wr_err(32'h0000_8000); step();
        chk("R7 ie set", err_reg, 32'h0000_8000);
        wr_err(32'hFFFF_FFFF); step();
        chk("R7 all ones", err_reg, 32'h0000_8000);
        wr_err(32'h0); step();
        chk("R7 ie cleared", err_reg, 32'h0);
    endtask

    task automatic t_w1c();
        do_reset();
        crd_evt = 1; step();
        chk("R8 crd set", err_reg, 32'h0000_4000);
        wr_err(32'h0000_4000); step();
        chk("R8 crd w1c", err_reg, 32'h0);
        cnf_evt = 1; step();
        wr_err(32'h0000_0100); step();
        chk("R8 bit8 not w1c", err_reg, 32'h0000_0100);
    endtask

    task automatic t_group();
        do_reset();
        timeout(32'h0000_0010, 1, 0, 2'b00); step();
        cnf_evt = 1; step();
        cnf_evt = 1; step();
        chk("R9 setup", err_reg, 32'h0000_1104);
        wr_err(32'h0000_0040); step();
        chk("R9 bit6 group leaves 12/8/2", err_reg, 32'h0000_1104);
        wr_err(32'h0000_1000); step();
        chk("R9 bit12 group", err_reg, 32'h0);
    endtask

    task automatic t_crd();
        do_reset();
        wr_err(32'h0000_8000); step();
        chk("R10 ie only", {31'b0, crd_irq}, 32'h0);
        crd_evt = 1; step();
        chk("R10 crd bit", err_reg, 32'h0000_C000);
        chk("R10 no update without write", {31'b0, crd_irq}, 32'h0);
        wr_err(32'h0000_8000); step();
        chk("R10 irq on write", {31'b0, crd_irq}, 32'h1);
        wr_err(32'h0); step();
        chk("R10 irq off", {31'b0, crd_irq}, 32'h0);
        chk("R10 crd kept", err_reg, 32'h0000_4000);
    endtask

    task automatic t_mchk_clear();
        do_reset();
        wr_err(32'h0000_8000); step();
        crd_evt = 1; step();
        timeout(32'h0000_0020, 1, 0, 2'b00); step();
        cnf_evt = 1; step();
        cnf_evt = 1; step();
        chk("R11 setup", err_reg, 32'h0000_D104);
        mchk_clr = 1; step();
        chk("R11 cleared", err_reg, 32'h0000_C000);
        timeout(32'h0000_0400, 1, 0, 2'b00); step();
        chk("R11 new capture", tmo_addr, 32'h0000_0100);
        chk("R11 flag again", err_reg, 32'h0000_D000);
    endtask

    task automatic t_priority();
        do_reset();
        timeout(32'h0000_0800, 1, 0, 2'b00); wr_err(32'h0000_1000); step();
        chk("R12 tmo beats w1c", err_reg, 32'h0000_1000);
        chk("R12 addr", tmo_addr, 32'h0000_0200);
        do_reset();
        cnf_evt = 1; mchk_clr = 1; step();
        chk("R12 cnf beats mchk_clr", err_reg, 32'h0000_0100);
    endtask

    task automatic t_addr_ro();
        do_reset();
        wr_err(32'h0000_8000); step();
        crd_evt = 1; step();
        timeout(32'h0000_0044, 1, 0, 2'b00); step();
        reg_wr = 1; reg_sel = 1; reg_wdata = 32'hFFFF_FFFF; step();
        chk("R13 addr unchanged", tmo_addr, 32'h0000_0011);
        chk("R13 err unchanged", err_reg, 32'h0000_D000);
        chk("R13 crd_irq not updated", {31'b0, crd_irq}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_phys_capture();
        t_virt_capture();
        t_multi();
        t_confirm();
        t_requests();
        t_mask_write();
        t_w1c();
        t_group();
        t_crd();
        t_mchk_clear();
        t_priority();
        t_addr_ro();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule